// File: doc/BRIEF.md
# Load Ordering Hazard Checker

This block sits beside the store and cache-maintenance queue of a load-store unit. Each cycle it looks at every queue slot: its kind, its block address and its sequence age. It decides whether the one candidate load presented that cycle may go ahead of the older pending entries, or must stall. Write-back and invalidate style maintenance entries are ordered like writes. They also hold back any later load that falls in the same cache block, even when forwarding is available. Block-zeroing entries are treated exactly as plain stores. Prefetch hints impose no ordering of any kind.

The same queue view also answers a second question. It reports whether a fence that orders prior writes may proceed, meaning that nothing older than the fence that counts as a write is still pending. Data forwarding, the cache and the memory write are handled elsewhere. A separate forwarding unit tells this block, through `fwd_en`, whether an overlapping plain store could be bypassed.

Both decisions are registered and appear one clock after the inputs that produced them.

Top module: `ldord_hazard_chk`

## Requirements
- R1: A valid older entry of kind 2'b00 (store) in the same block as the load causes `ld_stall` when `fwd_en` is 0 and `ld_go` when `fwd_en` is 1. Same block means the two addresses are equal once their low BLK_LG bits are cleared.
- R2: A valid older entry of kind 2'b01 (cache maintenance) in the same block as the load causes `ld_stall` whatever the value of `fwd_en`.
- R3: A valid entry of kind 2'b10 (block zero) behaves exactly like a store, both for loads and for fences.
- R4: A valid entry of kind 2'b11 (prefetch) never stalls a load and never holds a fence.
- R5: An entry never stalls a load if it is invalid, lies in a different block, or is not older than the load. An entry is older when (entry_age - other_age) taken modulo 2^AGE_W has its top bit set, so the comparison wraps around.
- R6: One cycle after `ld_vld` is 1, exactly one of `ld_go` and `ld_stall` is 1. One cycle after `ld_vld` is 0, both are 0.
- R7: One cycle after the fence inputs are sampled, `fence_drained` is 1 in either of two cases: `fence_pw` is 0, or no valid non-prefetch entry is older than `fence_age`.
- R8: While `rst_n` is low, `ld_go`, `ld_stall` and `fence_drained` are all 0. Reset takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_vld | input | N_ENT | Per-slot valid |
| q_kind | input | 2*N_ENT | Per-slot kind: 00 store, 01 maintenance, 10 zero, 11 prefetch |
| q_addr | input | ADDR_W*N_ENT | Per-slot byte address |
| q_age | input | AGE_W*N_ENT | Per-slot sequence age |
| ld_vld | input | 1 | Candidate load present |
| ld_addr | input | ADDR_W | Load byte address |
| ld_age | input | AGE_W | Load sequence age |
| fwd_en | input | 1 | Forwarding could bypass an overlapping store |
| fence_pw | input | 1 | Fence predecessor set contains writes or output |
| fence_age | input | AGE_W | Fence sequence age |
| ld_go | output | 1 | Load may issue |
| ld_stall | output | 1 | Load must wait |
| fence_drained | output | 1 | Fence may proceed |

## Verification
The bench builds the block with four slots, 16-bit addresses, 16-byte blocks and 4-bit ages. With a 4-bit age, sequence wrap-around can be reached with small numbers, so both sides of the modulo age comparison are tested directly. Four slots are enough to place each kind of entry in a different slot. They also allow a harmless prefetch to sit beside a blocking maintenance entry for the same load. The 16-byte block keeps the addresses that fall just inside and just outside a block boundary easy to write out.

// File: rtl/ldord_pkg.sv
package ldord_pkg;
  typedef enum logic [1:0] {
    K_STORE = 2'b00,
    K_CMO   = 2'b01,
    K_ZERO  = 2'b10,
    K_PREF  = 2'b11
  } ent_kind_e;
endpackage

// File: rtl/ldord_slot_eval.sv
module ldord_slot_eval
  import ldord_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 5,
  parameter int BLK_LG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_vld,
  input  logic [1:0]        e_kind,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [AGE_W-1:0]  e_age,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic              fwd_en,
  input  logic [AGE_W-1:0]  fn_age,
  output logic              ld_blk,
  output logic              fn_pend
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_LG) - ADDR_W'(1));

  logic [AGE_W-1:0] ld_diff, fn_diff;
  logic             older_ld, older_fn, same_blk, is_wr;
  ent_kind_e        kind;

  always_comb begin
    kind     = ent_kind_e'(e_kind);
    ld_diff  = e_age - ld_age;
    fn_diff  = e_age - fn_age;
    older_ld = ld_diff[AGE_W-1];
    older_fn = fn_diff[AGE_W-1];
    same_blk = (((e_addr ^ ld_addr) & BLK_MASK) == '0);
    is_wr    = (kind == K_STORE) || (kind == K_ZERO);
    ld_blk   = e_vld && older_ld && same_blk &&
               ((kind == K_CMO) || (is_wr && !fwd_en));
    fn_pend  = e_vld && older_fn && (kind != K_PREF);
  end

  // R4: a prefetch slot never reports a hazard of any kind
  a_r4_pref_free: assert property (@(posedge clk) disable iff (!rst_n)
    (e_kind == 2'b11) |-> (!ld_blk && !fn_pend));
  // R5: an invalid slot is silent
  a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !e_vld |-> (!ld_blk && !fn_pend));
endmodule

// File: rtl/ldord_hazard_chk.sv
module ldord_hazard_chk
  import ldord_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 5,
  parameter int BLK_LG = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_ENT-1:0]        q_vld,
  input  logic [2*N_ENT-1:0]      q_kind,
  input  logic [ADDR_W*N_ENT-1:0] q_addr,
  input  logic [AGE_W*N_ENT-1:0]  q_age,
  input  logic                    ld_vld,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [AGE_W-1:0]        ld_age,
  input  logic                    fwd_en,
  input  logic                    fence_pw,
  input  logic [AGE_W-1:0]        fence_age,
  output logic                    ld_go,
  output logic                    ld_stall,
  output logic                    fence_drained
);
  logic [N_ENT-1:0] blk_vec, pend_vec;
  logic             go_d, stall_d, drn_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    ldord_slot_eval #(
      .ADDR_W(ADDR_W), .AGE_W(AGE_W), .BLK_LG(BLK_LG)
    ) slot_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .e_vld  (q_vld[g]),
      .e_kind (q_kind[2*g +: 2]),
      .e_addr (q_addr[ADDR_W*g +: ADDR_W]),
      .e_age  (q_age[AGE_W*g +: AGE_W]),
      .ld_addr(ld_addr),
      .ld_age (ld_age),
      .fwd_en (fwd_en),
      .fn_age (fence_age),
      .ld_blk (blk_vec[g]),
      .fn_pend(pend_vec[g])
    );
  end

  always_comb begin
    go_d    = ld_vld && !(|blk_vec);
    stall_d = ld_vld &&  (|blk_vec);
    drn_d   = !fence_pw || !(|pend_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_go         <= 1'b0;
      ld_stall      <= 1'b0;
      fence_drained <= 1'b0;
    end else begin
      ld_go         <= go_d;
      ld_stall      <= stall_d;
      fence_drained <= drn_d;
    end
  end

  // R6: at most one response at a time
  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_go && ld_stall));
  // R6: a presented load always gets an answer on the next cycle
  a_r6_resp: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |=> (ld_go || ld_stall));
  // R6: no load, no answer
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |=> (!ld_go && !ld_stall));
  // R7: a fence that orders no writes never waits
  a_r7_no_pw: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_pw |=> fence_drained);
endmodule

// File: tb/ldord_hazard_chk_tb_top.sv
module ldord_hazard_chk_tb_top;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int GW = 4;
  localparam int NV = 13;

  typedef struct packed {
    logic [1:0]  slot;
    logic        vld;
    logic [1:0]  kind;
    logic [15:0] ea;
    logic [3:0]  eg;
    logic [15:0] la;
    logic [3:0]  lg;
    logic        fwd;
    logic        fpw;
    logic [3:0]  fg;
    logic        go;
    logic        st;
    logic        dr;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b1,2'b00,16'h1230,4'd3, 16'h1238,4'd5, 1'b0,1'b1,4'd6, 1'b0,1'b1,1'b0,4'd1}, // R1 stall
    '{2'd0,1'b1,2'b00,16'h1230,4'd3, 16'h1238,4'd5, 1'b1,1'b1,4'd6, 1'b1,1'b0,1'b0,4'd1}, // R1 forward
    '{2'd0,1'b1,2'b00,16'h1230,4'd3, 16'h1240,4'd5, 1'b0,1'b1,4'd2, 1'b1,1'b0,1'b1,4'd5}, // R5 other block
    '{2'd1,1'b1,2'b01,16'h1230,4'd3, 16'h123F,4'd5, 1'b1,1'b1,4'd6, 1'b0,1'b1,1'b0,4'd2}, // R2
    '{2'd1,1'b1,2'b01,16'h1230,4'd3, 16'h1220,4'd5, 1'b0,1'b1,4'd6, 1'b1,1'b0,1'b0,4'd5}, // R5
    '{2'd1,1'b1,2'b01,16'h1230,4'd7, 16'h1230,4'd5, 1'b0,1'b1,4'd6, 1'b1,1'b0,1'b1,4'd5}, // R5 younger
    '{2'd2,1'b1,2'b10,16'h1230,4'd3, 16'h1234,4'd5, 1'b0,1'b1,4'd6, 1'b0,1'b1,1'b0,4'd3}, // R3
    '{2'd2,1'b1,2'b10,16'h1230,4'd3, 16'h1234,4'd5, 1'b1,1'b1,4'd6, 1'b1,1'b0,1'b0,4'd3}, // R3
    '{2'd3,1'b1,2'b11,16'h1230,4'd3, 16'h1230,4'd5, 1'b0,1'b1,4'd6, 1'b1,1'b0,1'b1,4'd4}, // R4
    '{2'd0,1'b0,2'b00,16'h1230,4'd3, 16'h1230,4'd5, 1'b0,1'b1,4'd6, 1'b1,1'b0,1'b1,4'd5}, // R5 invalid
    '{2'd0,1'b1,2'b00,16'h1230,4'd3, 16'h1238,4'd5, 1'b0,1'b0,4'd6, 1'b0,1'b1,1'b1,4'd7}, // R7
    '{2'd1,1'b1,2'b01,16'h1230,4'd14,16'h1230,4'd1, 1'b0,1'b1,4'd2, 1'b0,1'b1,1'b0,4'd5}, // R5 wrap
    '{2'd1,1'b1,2'b01,16'h1230,4'd1, 16'h1230,4'd14,1'b0,1'b1,4'd14,1'b1,1'b0,1'b1,4'd5}  // R5 wrap
  };

  logic            clk, rst_n;
  logic [N-1:0]    q_vld;
  logic [2*N-1:0]  q_kind;
  logic [AW*N-1:0] q_addr;
  logic [GW*N-1:0] q_age;
  logic            ld_vld, fwd_en, fence_pw;
  logic [AW-1:0]   ld_addr;
  logic [GW-1:0]   ld_age, fence_age;
  logic            ld_go, ld_stall, fence_drained;
  int              checks, errors;
  bit              done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  ldord_hazard_chk #(.N_ENT(N), .ADDR_W(AW), .AGE_W(GW), .BLK_LG(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_vld(q_vld), .q_kind(q_kind), .q_addr(q_addr),
    .q_age(q_age), .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_age(ld_age),
    .fwd_en(fwd_en), .fence_pw(fence_pw), .fence_age(fence_age),
    .ld_go(ld_go), .ld_stall(ld_stall), .fence_drained(fence_drained));

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic clear_q();
    q_vld = '0; q_kind = '0; q_addr = '0; q_age = '0;
  endtask

  task automatic put(input int s, input logic v, input logic [1:0] k,
                     input logic [AW-1:0] a, input logic [GW-1:0] g);
    q_vld[s] = v; q_kind[2*s +: 2] = k; q_addr[AW*s +: AW] = a; q_age[GW*s +: GW] = g;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; clear_q();
    ld_vld = 1'b0; ld_addr = '0; ld_age = '0; fwd_en = 1'b0;
    fence_pw = 1'b0; fence_age = '0;
    repeat (3) @(negedge clk);
    chk("R8", "go in reset", ld_go, 1'b0);
    chk("R8", "stall in reset", ld_stall, 1'b0);
    chk("R8", "drained in reset", fence_drained, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clear_q();
      put(TBL[i].slot, TBL[i].vld, TBL[i].kind, TBL[i].ea, TBL[i].eg);
      ld_vld = 1'b1; ld_addr = TBL[i].la; ld_age = TBL[i].lg;
      fwd_en = TBL[i].fwd; fence_pw = TBL[i].fpw; fence_age = TBL[i].fg;
      @(negedge clk);
      chk(rname(TBL[i].req), $sformatf("vec%0d go", i), ld_go, TBL[i].go);
      chk(rname(TBL[i].req), $sformatf("vec%0d stall", i), ld_stall, TBL[i].st);
      chk(TBL[i].req == 4'd5 ? "R5/R7" : rname(TBL[i].req),
          $sformatf("vec%0d drained", i), fence_drained, TBL[i].dr);
    end

    // R6: no load presented
    ld_vld = 1'b0;
    @(negedge clk);
    chk("R6", "idle go", ld_go, 1'b0);
    chk("R6", "idle stall", ld_stall, 1'b0);

    // R2 R4: prefetch beside a blocking maintenance entry
    clear_q();
    put(0, 1'b1, 2'b11, 16'h0A50, 4'd2);
    put(2, 1'b1, 2'b01, 16'h0A58, 4'd3);
    ld_vld = 1'b1; ld_addr = 16'h0A5C; ld_age = 4'd6; fwd_en = 1'b1;
    fence_pw = 1'b1; fence_age = 4'd4;
    @(negedge clk);
    chk("R2", "multi stall", ld_stall, 1'b1);
    chk("R7", "multi drained", fence_drained, 1'b0);
    q_vld[2] = 1'b0;
    @(negedge clk);
    chk("R4", "prefetch only go", ld_go, 1'b1);
    chk("R4", "prefetch only drained", fence_drained, 1'b1);

    // R8: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8", "async clear go", ld_go, 1'b0);
    chk("R8", "async clear drained", fence_drained, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule